// File: doc/BRIEF.md
# Synchronized DMA Channel Sequencer

One general-purpose DMA channel that copies a programmed number of words from a source address range to a destination address range. Every word takes two bus phases on a simple master port: a one-cycle read at the source address, then a one-cycle write of the same word to the destination address. After each write, the source and destination addresses each step up, step down, or stay fixed, as the configuration sets them. A 16-bit count sets how many words move. When the count runs out, the channel goes idle and raises a sticky done flag.

Transfers can be paced in three ways. An unsynchronized run starts from a software start pulse and needs no request at all. A source-paced run moves one word each time the selected request is high and the channel is waiting. A destination-paced run does the same, except that the request is ignored for a fixed window after each write strobe. During that window the channel drops its bus request, so other masters can use the bus, and the target device has time to lower its request line. The request can come from one of four places: either of two asynchronous external pins (each passed through a synchronizer), a timer tick, or a serial-port request. The timer tick only paces the transfers. The addresses always come from the configuration.

Top module: `dma_seq_chan`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, bus_req, bus_rd, bus_wr, busy and done are all 0.
- R2: Each word is moved as a one-cycle bus_rd, immediately followed in the next cycle by a one-cycle bus_wr. bus_wdata equals the bus_rdata value that was presented during the read cycle.
- R3: The address step codes are 0 = fixed, 1 = +1, 2 = -1 and 3 = fixed, and addresses wrap at 16 bits. The n-th read (counting from 0) uses source base plus n times the source step. The n-th write uses destination base plus n times the destination step.
- R4: A run moves exactly cfg_count words. done is set and busy is cleared in the cycle that follows the last write. A count of 0 sets done in the cycle after start, with no bus activity. An accepted start clears done.
- R5: In unsynchronized mode, the words move back to back, one write every 4 cycles, with no request input involved.
- R6: Request source select codes are 0 = external pin 0, 1 = external pin 1, 2 = timer tick and 3 = serial request. Requests that are not selected have no effect. A single-cycle timer tick, seen while the channel waits, moves exactly one word.
- R7: External pins pass through a two-flop synchronizer. When the channel is waiting and a pin is raised, the first bus_rd comes 4 clock edges later. A serial request raised in the same situation produces its first bus_rd 2 edges later.
- R8: In source-paced mode, a request held high produces one write every 4 cycles. If the request is dropped during the fetch cycle, no further word moves until the request returns.
- R9: In destination-paced mode, bus_req is low for the 4 cycles after each write that is not the last. A request held high gives one write every 8 cycles. If the request is dropped in the write cycle, no further word moves until it returns.
- R10: bus_req is raised before any access. No read is issued until bus_gnt is high, and the read comes in the cycle after the grant is seen.
- R11: A start pulse while busy is ignored. The run in progress keeps its configuration.
- R12: Mode codes are 0 = unsynchronized, 1 = source-paced, 2 = destination-paced and 3 = unsynchronized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load the configuration and begin a run (only when idle) |
| cfg_mode | input | 2 | Pacing mode code |
| cfg_req_sel | input | 2 | Request source code |
| cfg_src_step | input | 2 | Source address step code |
| cfg_dst_step | input | 2 | Destination address step code |
| cfg_src_base | input | 16 | First source address |
| cfg_dst_base | input | 16 | First destination address |
| cfg_count | input | 16 | Number of words to move |
| ext_req | input | 2 | Asynchronous external request pins |
| tmr_tick | input | 1 | Timer pacing request |
| uart_req | input | 1 | Serial-port request |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant, held while bus_req is high |
| bus_addr | output | 16 | Access address |
| bus_rd | output | 1 | Read strobe, one cycle |
| bus_wr | output | 1 | Write strobe, one cycle |
| bus_rdata | input | 16 | Read data, sampled at the end of the read cycle |
| bus_wdata | output | 16 | Write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky completion flag |

## Verification
Each result has a fixed due time, counted in rising edges from a stimulus that is applied at a falling edge. The bench samples every output at falling edges only.

- A start pulse leads to its first read 3 edges later.
- A granted request leads to its read 1 edge later.
- A serial request leads to its read 2 edges later.
- A raised external pin leads to its read 4 edges later.

The bench measures each of these distances with a free-running edge counter. A monitor compares every read and write address, and every write word, against an arithmetic expectation. The monitor also checks the spacing between writes: 4 edges, or 8 in destination-paced mode. Checks that a transfer stopped or that a request was ignored wait well past the longest of these distances before they look at the write count, busy and done.

// File: rtl/dma_seq_pkg.sv
// Shared types for the synchronized DMA channel sequencer.
// Assumes 2-bit configuration codes, cast to these enums at the block edge.
package dma_seq_pkg;

    // Pacing mode; code 3 behaves like code 0
    typedef enum logic [1:0] {
        MODE_FREE  = 2'd0,
        MODE_SRC   = 2'd1,
        MODE_DST   = 2'd2,
        MODE_FREE3 = 2'd3
    } sync_mode_e;

    // Address step per word; code 3 behaves like code 0
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_UP    = 2'd1,
        STEP_DOWN  = 2'd2,
        STEP_HOLD3 = 2'd3
    } step_e;

    // Request source selection
    typedef enum logic [1:0] {
        SEL_PIN0  = 2'd0,
        SEL_PIN1  = 2'd1,
        SEL_TIMER = 2'd2,
        SEL_UART  = 2'd3
    } req_sel_e;

    // Channel sequencer states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT    = 3'd1,
        ST_ARB     = 3'd2,
        ST_FETCH   = 3'd3,
        ST_DEPOSIT = 3'd4,
        ST_MASK    = 3'd5
    } chan_state_e;

endpackage

// File: rtl/dma_req_front.sv
// Request front end: synchronizes the asynchronous external pins, latches
// the source selection when a run is loaded and presents one request level.
// Assumes timer and serial requests are already synchronous to clk.
module dma_req_front
    import dma_seq_pkg::*;
#(
    parameter int NPIN   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [1:0]      cfg_sel,
    input  logic [NPIN-1:0] ext_pin,
    input  logic            tmr_tick,
    input  logic            uart_req,
    output logic            req
);

    logic [NPIN-1:0] pin_sync;
    req_sel_e        sel_q;

    // One synchronizer chain per external pin
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [STAGES-1:0] chain;

        // Shift the raw pin level through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], ext_pin[p]};
        end

        assign pin_sync[p] = chain[STAGES-1];
    end

    // Capture the selected source when a run is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)    sel_q <= SEL_PIN0;
        else if (load) sel_q <= req_sel_e'(cfg_sel);
    end

    // Pick the active request level
    always_comb begin
        unique case (sel_q)
            SEL_PIN0:  req = pin_sync[0];
            SEL_PIN1:  req = pin_sync[1];
            SEL_TIMER: req = tmr_tick;
            SEL_UART:  req = uart_req;
            default:   req = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_addr_step.sv
// Address walker: loads a base address and, on each advance, steps it up,
// down or holds it as the step code says. Wraps at AW bits.
// Assumes load and adv are never both high.
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [1:0]    step_cfg,
    input  logic          adv,
    output logic [AW-1:0] addr
);

    step_e step_q;

    // Hold the base and step for the run, then walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            step_q <= STEP_HOLD;
        end else if (load) begin
            addr   <= base;
            step_q <= step_e'(step_cfg);
        end else if (adv) begin
            unique case (step_q)
                STEP_UP:   addr <= addr + AW'(1);
                STEP_DOWN: addr <= addr - AW'(1);
                default:   addr <= addr;
            endcase
        end
    end

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && step_q == STEP_UP) |=> addr == $past(addr) + AW'(1));

    // R3
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && step_q == STEP_DOWN) |=> addr == $past(addr) - AW'(1));

endmodule

// File: rtl/dma_chan_ctrl.sv
// Channel sequencer: accepts a start, waits for pacing, acquires the bus,
// runs the fetch and deposit phases, counts words and masks the request
// after each deposit in destination-paced mode.
// Assumes bus_gnt stays high while bus_req is high once it has been given.
module dma_chan_ctrl
    import dma_seq_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int MASK_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cfg_mode,
    input  logic [CW-1:0] cfg_count,
    input  logic          req,
    input  logic          bus_gnt,
    input  logic [DW-1:0] bus_rdata,
    output logic          load,
    output logic          adv,
    output logic          bus_req,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    output logic          busy,
    output logic          done
);

    localparam int            MW        = $clog2(MASK_CYC + 1);
    localparam logic [MW-1:0] MASK_LAST = MW'(MASK_CYC - 1);

    chan_state_e   state;
    sync_mode_e    mode_q;
    logic [CW-1:0] cnt;
    logic [MW-1:0] mask_cnt;
    logic [DW-1:0] data_q;
    logic          done_q;
    logic          free_run;
    logic          last_word;

    // Unsynchronized runs ignore the request input
    assign free_run  = (mode_q == MODE_FREE) || (mode_q == MODE_FREE3);
    assign last_word = (cnt == CW'(1));
    assign load      = (state == ST_IDLE) && start;

    // Sequencer state, word count, mask window and data latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mode_q   <= MODE_FREE;
            cnt      <= '0;
            mask_cnt <= '0;
            data_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q <= sync_mode_e'(cfg_mode);
                        cnt    <= cfg_count;
                        if (cfg_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            done_q <= 1'b0;
                            state  <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (free_run || req) state <= ST_ARB;
                end
                ST_ARB: begin
                    if (bus_gnt) state <= ST_FETCH;
                end
                ST_FETCH: begin
                    data_q <= bus_rdata;
                    state  <= ST_DEPOSIT;
                end
                ST_DEPOSIT: begin
                    cnt <= cnt - CW'(1);
                    if (last_word) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (mode_q == MODE_DST) begin
                        mask_cnt <= MASK_LAST;
                        state    <= ST_MASK;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_MASK: begin
                    if (mask_cnt == '0) state <= ST_WAIT;
                    else                mask_cnt <= mask_cnt - MW'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus-side strobes decoded from the state
    always_comb begin
        bus_req = (state == ST_ARB) || (state == ST_FETCH) || (state == ST_DEPOSIT);
        bus_rd  = (state == ST_FETCH);
        bus_wr  = (state == ST_DEPOSIT);
        adv     = (state == ST_DEPOSIT);
        busy    = (state != ST_IDLE);
    end

    assign bus_wdata = data_q;
    assign done      = done_q;

    // R2
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_wr);

    // R4
    word_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> cnt == $past(cnt) - CW'(1));

    // R4
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(bus_wr) || $past(load)));

    // R9
    mask_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && mode_q == MODE_DST && !last_word) |=> !bus_req);

endmodule

// File: rtl/dma_seq_chan.sv
// Top of the synchronized DMA channel: request front end, two address
// walkers and the sequencer. Fetch uses the source walker, deposit the
// destination walker.
// Assumes single-cycle bus accesses once the grant is held.
module dma_seq_chan
    import dma_seq_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int NPIN     = 2,
    parameter int STAGES   = 2,
    parameter int MASK_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      cfg_mode,
    input  logic [1:0]      cfg_req_sel,
    input  logic [1:0]      cfg_src_step,
    input  logic [1:0]      cfg_dst_step,
    input  logic [AW-1:0]   cfg_src_base,
    input  logic [AW-1:0]   cfg_dst_base,
    input  logic [CW-1:0]   cfg_count,
    input  logic [NPIN-1:0] ext_req,
    input  logic            tmr_tick,
    input  logic            uart_req,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_rd,
    output logic            bus_wr,
    input  logic [DW-1:0]   bus_rdata,
    output logic [DW-1:0]   bus_wdata,
    output logic            busy,
    output logic            done
);

    logic          load;
    logic          adv;
    logic          req;
    logic [AW-1:0] src_addr;
    logic [AW-1:0] dst_addr;

    dma_req_front #(.NPIN(NPIN), .STAGES(STAGES)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cfg_sel  (cfg_req_sel),
        .ext_pin  (ext_req),
        .tmr_tick (tmr_tick),
        .uart_req (uart_req),
        .req      (req)
    );

    dma_addr_step #(.AW(AW)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .base     (cfg_src_base),
        .step_cfg (cfg_src_step),
        .adv      (adv),
        .addr     (src_addr)
    );

    dma_addr_step #(.AW(AW)) u_dst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .base     (cfg_dst_base),
        .step_cfg (cfg_dst_step),
        .adv      (adv),
        .addr     (dst_addr)
    );

    dma_chan_ctrl #(.DW(DW), .CW(CW), .MASK_CYC(MASK_CYC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_mode  (cfg_mode),
        .cfg_count (cfg_count),
        .req       (req),
        .bus_gnt   (bus_gnt),
        .bus_rdata (bus_rdata),
        .load      (load),
        .adv       (adv),
        .bus_req   (bus_req),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .done      (done)
    );

    // Deposit drives the destination address, every other cycle the source
    assign bus_addr = bus_wr ? dst_addr : src_addr;

endmodule

// File: tb/sim_dma_seq_chan.sv
module sim_dma_seq_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_mode = '0, cfg_req_sel = '0, cfg_src_step = '0, cfg_dst_step = '0;
    logic [15:0] cfg_src_base = '0, cfg_dst_base = '0, cfg_count = '0;
    logic [1:0]  ext_req = '0;
    logic        tmr_tick = 1'b0, uart_req = 1'b0;
    logic        bus_req, bus_rd, bus_wr, busy, done;
    logic        bus_gnt = 1'b1;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;

    int errors = 0, checks = 0;
    int cyc = 0;

    // expectation state used by the monitor
    logic [15:0] e_sbase, e_dbase;
    logic [1:0]  e_sstep, e_dstep, e_mode;
    int          e_count = 0, e_gap = 0;
    int          rd_idx = 0, wr_idx = 0, last_wr = 0, mask_watch = 0, req_seen = 0;
    logic        prev_rd = 1'b0;
    bit          mon_on = 1'b0;

    // memory model: read word is a fixed function of the address
    assign bus_rdata = bus_addr ^ 16'h5A3C;

    dma_seq_chan u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .cfg_req_sel(cfg_req_sel), .cfg_src_step(cfg_src_step),
        .cfg_dst_step(cfg_dst_step), .cfg_src_base(cfg_src_base),
        .cfg_dst_base(cfg_dst_base), .cfg_count(cfg_count), .ext_req(ext_req),
        .tmr_tick(tmr_tick), .uart_req(uart_req), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .busy(busy), .done(done)
    );

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] walk(input logic [15:0] b, input logic [1:0] s, input int i);
        case (s)
            2'd1:    return b + 16'(i);
            2'd2:    return b - 16'(i);
            default: return b;
        endcase
    endfunction

    // monitor: addresses, data, phase order, spacing, mask window
    always @(negedge clk) begin
        if (mon_on) begin
            if (bus_req) req_seen++;
            if (mask_watch > 0) begin
                chk(!bus_req, "R9", "bus_req in mask window", bus_req, 0);
                mask_watch--;
            end
            if (bus_rd)
                chk(bus_addr == walk(e_sbase, e_sstep, rd_idx), "R3", "read addr",
                    bus_addr, walk(e_sbase, e_sstep, rd_idx));
            if (bus_wr) begin
                chk(prev_rd, "R2", "read precedes write", prev_rd, 1);
                chk(bus_addr == walk(e_dbase, e_dstep, wr_idx), "R3", "write addr",
                    bus_addr, walk(e_dbase, e_dstep, wr_idx));
                chk(bus_wdata == (walk(e_sbase, e_sstep, wr_idx) ^ 16'h5A3C), "R2",
                    "write data", bus_wdata, walk(e_sbase, e_sstep, wr_idx) ^ 16'h5A3C);
                chk(wr_idx < e_count, "R4", "extra word", wr_idx, e_count);
                if (e_gap != 0 && wr_idx > 0)
                    chk(cyc - last_wr == e_gap, (e_gap == 8) ? "R9" : "R8/R5",
                        "write spacing", cyc - last_wr, e_gap);
                if (e_mode == 2'd2 && wr_idx + 1 < e_count) mask_watch = 4;
                last_wr = cyc;
                wr_idx++;
            end
            if (bus_rd) rd_idx++;
            prev_rd = bus_rd;
        end
    end

    task automatic launch(input logic [1:0] mode, input logic [1:0] sel,
                          input logic [1:0] ss, input logic [1:0] ds,
                          input logic [15:0] sb, input logic [15:0] db,
                          input int n, input int gap);
        @(negedge clk);
        e_sbase = sb; e_dbase = db; e_sstep = ss; e_dstep = ds; e_mode = mode;
        e_count = n; e_gap = gap; rd_idx = 0; wr_idx = 0; mask_watch = 0;
        req_seen = 0; prev_rd = 1'b0; mon_on = 1'b1;
        cfg_mode = mode; cfg_req_sel = sel; cfg_src_step = ss; cfg_dst_step = ds;
        cfg_src_base = sb; cfg_dst_base = db; cfg_count = 16'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run(input string tag, input int n);
        int k = 0;
        while (!done && k < 400) begin @(negedge clk); k++; end
        chk(done, tag, "done raised", done, 1);
        chk(!busy, tag, "busy cleared", busy, 0);
        chk(wr_idx == n, "R4", "words moved", wr_idx, n);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        idle(3);
        chk(!bus_req && !bus_rd && !bus_wr, "R1", "bus idle in reset", {bus_req, bus_rd, bus_wr}, 0);
        chk(!busy && !done, "R1", "flags in reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !busy && !done, "R1", "after release", {bus_req, busy, done}, 0);

        // R3/R5: unsynchronized runs across all step code pairs
        for (int s = 0; s < 4; s++)
            for (int d = 0; d < 4; d++) begin
                launch(2'd0, 2'd0, 2'(s), 2'(d), 16'h0100 + 16'(s * 16),
                       16'hF000 + 16'(d * 16), 3, 4);
                finish_run("R5", 3);
            end
        // R12: mode code 3 runs unsynchronized
        launch(2'd3, 2'd0, 2'd1, 2'd2, 16'hFFFE, 16'h0001, 4, 4);
        finish_run("R12", 4);

        // R4: zero count
        launch(2'd0, 2'd0, 2'd1, 2'd1, 16'h0200, 16'h0300, 0, 0);
        chk(done && !busy, "R4", "zero count done", {done, busy}, 2);
        idle(10);
        chk(req_seen == 0, "R4", "zero count bus quiet", req_seen, 0);

        // R6/R8: each source held high in source-paced mode
        for (int sel = 0; sel < 4; sel++) begin
            case (sel)
                0: ext_req = 2'b01;
                1: ext_req = 2'b10;
                2: tmr_tick = 1'b1;
                default: uart_req = 1'b1;
            endcase
            idle(3);
            launch(2'd1, 2'(sel), 2'd1, 2'd1, 16'h0400 + 16'(sel * 32), 16'h0800, 4, 4);
            finish_run("R6", 4);
            ext_req = '0; tmr_tick = 1'b0; uart_req = 1'b0;
            idle(3);
        end

        // R6: unselected requests do nothing
        launch(2'd1, 2'd1, 2'd0, 2'd1, 16'h0500, 16'h0600, 2, 0);
        ext_req = 2'b01; tmr_tick = 1'b1; uart_req = 1'b1;
        idle(20);
        chk(req_seen == 0 && wr_idx == 0, "R6", "unselected ignored", wr_idx, 0);
        chk(busy, "R6", "still waiting", busy, 1);
        ext_req = 2'b11;
        finish_run("R6", 2);
        ext_req = '0; tmr_tick = 1'b0; uart_req = 1'b0;
        idle(3);

        // R6: one timer tick moves one word
        launch(2'd1, 2'd2, 2'd1, 2'd1, 16'h0700, 16'h0900, 2, 0);
        idle(3);
        tmr_tick = 1'b1; @(negedge clk); tmr_tick = 1'b0;
        idle(15);
        chk(wr_idx == 1, "R6", "single tick one word", wr_idx, 1);
        tmr_tick = 1'b1; @(negedge clk); tmr_tick = 1'b0;
        finish_run("R6", 2);

        // R7: serial request latency, then synchronized pin latency
        for (int p = 0; p < 2; p++) begin
            int t0;
            int k = 0;
            launch(2'd1, p == 0 ? 2'd3 : 2'd0, 2'd0, 2'd0, 16'h0A00, 16'h0B00, 1, 0);
            idle(4);
            t0 = cyc;
            if (p == 0) uart_req = 1'b1; else ext_req = 2'b01;
            @(negedge clk);
            while (!bus_rd && k < 20) begin @(negedge clk); k++; end
            chk(cyc - t0 == (p == 0 ? 2 : 4), "R7", "request to read edges",
                cyc - t0, p == 0 ? 2 : 4);
            finish_run("R7", 1);
            uart_req = 1'b0; ext_req = '0;
            idle(4);
        end

        // R8: source-paced request dropped during fetch stops transfers
        begin
            int k = 0;
            ext_req = 2'b01; idle(3);
            launch(2'd1, 2'd0, 2'd1, 2'd2, 16'h0C00, 16'h0D40, 5, 0);
            while (!bus_rd && k < 20) begin @(negedge clk); k++; end
            ext_req = 2'b00;
            idle(30);
            chk(wr_idx == 1, "R8", "stopped after drop", wr_idx, 1);
            chk(busy && !done, "R8", "run still open", {busy, done}, 2);
            ext_req = 2'b01;
            finish_run("R8", 5);
            ext_req = '0; idle(3);
        end

        // R9: destination-paced, held request, spacing and mask window
        ext_req = 2'b01; idle(3);
        launch(2'd2, 2'd0, 2'd2, 2'd1, 16'h0E10, 16'h0F00, 3, 8);
        finish_run("R9", 3);
        ext_req = '0; idle(3);

        // R9: device drops its request in the write cycle
        begin
            int k = 0;
            ext_req = 2'b01; idle(3);
            launch(2'd2, 2'd0, 2'd1, 2'd1, 16'h1000, 16'h1100, 3, 0);
            while (!bus_wr && k < 20) begin @(negedge clk); k++; end
            ext_req = 2'b00;
            idle(30);
            chk(wr_idx == 1, "R9", "drop in window stops", wr_idx, 1);
            ext_req = 2'b01;
            finish_run("R9", 3);
            ext_req = '0; idle(3);
        end

        // R10: no read before grant
        begin
            int t0;
            bus_gnt = 1'b0;
            launch(2'd0, 2'd0, 2'd1, 2'd1, 16'h1200, 16'h1300, 1, 0);
            idle(10);
            chk(bus_req && rd_idx == 0, "R10", "waiting for grant", rd_idx, 0);
            t0 = cyc;
            bus_gnt = 1'b1;
            @(negedge clk);
            chk(bus_rd && cyc - t0 == 1, "R10", "read one edge after grant", cyc - t0, 1);
            finish_run("R10", 1);
        end

        // R11: start while busy is ignored
        begin
            int k = 0;
            launch(2'd0, 2'd0, 2'd1, 2'd1, 16'h1400, 16'h1500, 4, 4);
            while (!bus_rd && k < 20) begin @(negedge clk); k++; end
            cfg_mode = 2'd2; cfg_src_base = 16'h7777; cfg_dst_base = 16'h8888;
            cfg_count = 16'd9; cfg_src_step = 2'd2;
            start = 1'b1; @(negedge clk); start = 1'b0;
            finish_run("R11", 4);
            idle(10);
            chk(!busy && wr_idx == 4, "R11", "no second run", wr_idx, 4);
        end

        mon_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule